// File: doc/BRIEF.md
# Streaming Bitonic Key Sorter

The block sorts a continuous stream of fixed-size blocks of N unsigned keys. Each block arrives over N/P consecutive cycles, P keys per cycle. It leaves in ascending order at the same rate, so a new block can follow the previous one on the very next cycle. Within a cycle, lane j carries the key at position c*P + j of the block, where c is the cycle number inside the block. On both the input and the output side, a block-start flag marks the cycle that has c = 0.

Inside, the block runs every compare-exchange column of a bitonic sorting network in turn. The network has log2(N)*(log2(N)+1)/2 columns, and each column is mapped onto a P-wide pipeline stage. When the two partner keys of a column sit in the same cycle (partner distance below P), the stage is a row of compare-exchange units wired directly between lanes. When the partners sit in different cycles (distance D*P with D at least 1), a D-entry delay line holds the earlier word. When the partner word arrives, the stage emits the lower result at once and stores the upper result in the delay line, so that it leaves D cycles later. The whole stream passes through such a stage delayed by D cycles, and no word changes its order in the stream. Every stage ends in a register.

Top module: `bsn_sorter`

## Requirements
- R1: While out_valid is high, the keys of each output block are non-decreasing across lanes 0..P-1 of a cycle and from lane P-1 of one cycle to lane 0 of the next, using unsigned comparison.
- R2: Each output block holds exactly the multiset of keys of the corresponding input block.
- R3: A word presented with in_valid in cycle k appears on the outputs in cycle k+L. L is the sum over all network columns of 1 + D, where D = distance/P for columns whose partner distance is at least P and D = 0 otherwise (L = 14 for N=16, P=4).
- R4: Blocks given on consecutive cycles with no gap leave on consecutive cycles with no gap, at P keys per cycle.
- R5: out_start is high in exactly the first output cycle of each block and low in every other cycle.
- R6: During reset and after reset until the first due output, out_valid and out_start are low.
- R7: Idle cycles (in_valid low) between blocks are allowed; out_valid is low in the cycles exactly L after them.
- R8: Duplicate keys and the extreme values 0 and 2^KW-1 are sorted correctly; equal keys may leave in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid; held high for all N/P cycles of a block |
| in_start | input | 1 | High with the first word of an input block |
| in_keys | input | P*KW | Input keys, lane j in bits j*KW +: KW |
| out_valid | output | 1 | Output word valid |
| out_start | output | 1 | High with the first word of an output block |
| out_keys | output | P*KW | Sorted keys, lane j in bits j*KW +: KW |

## Verification
Each output word is due exactly L cycles after the cycle in which its input word was presented: 14 cycles with the default parameters, one cycle per network column plus the delay-line depths. The bench works out L from the column list on its own. When a block is complete it sorts the block, and it queues every output word with the cycle in which that word is due. In each cycle it samples the outputs on the falling edge. If the head of the queue is due in that cycle, it compares valid, start and all lanes against that entry. If nothing is due, it requires out_valid to be low. A word that arrives early or late therefore fails both the valid check and the data check.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

  // number of compare-exchange columns in a bitonic network of 2**logn keys
  function automatic int f_stage_count(int logn);
    return logn * (logn + 1) / 2;
  endfunction

  // direction of the pair whose lower element sits at global index gidx,
  // within a merge of span keys: ascending when the span bit is clear
  function automatic bit f_ascending(int gidx, int span);
    return (gidx & span) == 0;
  endfunction

  // true when the pair (lo, hi) must be exchanged for the given direction
  function automatic bit f_needs_swap(bit asc, logic [31:0] lo, logic [31:0] hi);
    return asc ? (lo > hi) : (lo < hi);
  endfunction

endpackage

// File: rtl/bsn_lane_stage.sv
module bsn_lane_stage #(
  parameter int P    = 4,
  parameter int KW   = 16,
  parameter int CW   = 2,
  parameter int SPAN = 2,
  parameter int DIST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_vld,
  input  logic [CW-1:0] i_idx,
  input  logic [P*KW-1:0] i_dat,
  output logic          o_vld,
  output logic [CW-1:0] o_idx,
  output logic [P*KW-1:0] o_dat
);

  logic [P*KW-1:0] nxt_dat;
  logic [P-1:0]    cx_swap;   // lane j holds the exchange decision of pair (j, j+DIST)

  always_comb begin
    logic [KW-1:0] a;
    logic [KW-1:0] b;
    nxt_dat = i_dat;
    cx_swap = '0;
    a = '0;
    b = '0;
    for (int j = 0; j < P; j++) begin
      if ((j & DIST) == 0) begin
        a = i_dat[j*KW +: KW];
        b = i_dat[(j+DIST)*KW +: KW];
        cx_swap[j] = bsn_pkg::f_needs_swap(
                       bsn_pkg::f_ascending(int'(i_idx) * P + j, SPAN),
                       32'(a), 32'(b));
        if (cx_swap[j]) begin
          nxt_dat[j*KW +: KW]        = b;
          nxt_dat[(j+DIST)*KW +: KW] = a;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld <= 1'b0;
      o_idx <= '0;
      o_dat <= '0;
    end else begin
      o_vld <= i_vld;
      o_idx <= i_idx;
      o_dat <= nxt_dat;
    end
  end

  for (genvar j = 0; j < P; j++) begin : g_chk
    if ((j & DIST) == 0) begin : g_pair
      // R1: every registered pair is ordered in its column's direction
      a_r1_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (bsn_pkg::f_ascending(int'(o_idx) * P + j, SPAN)
                   ? (o_dat[j*KW +: KW] <= o_dat[(j+DIST)*KW +: KW])
                   : (o_dat[j*KW +: KW] >= o_dat[(j+DIST)*KW +: KW])));
      // R2: an exchange moves the upper key into the lower lane, nothing is lost
      a_r2_swap_routes: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && cx_swap[j]) |=> o_dat[j*KW +: KW] == $past(i_dat[(j+DIST)*KW +: KW]));
    end
  end

endmodule

// File: rtl/bsn_delay_stage.sv
module bsn_delay_stage #(
  parameter int P    = 4,
  parameter int KW   = 16,
  parameter int CW   = 2,
  parameter int SPAN = 8,
  parameter int DIST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_vld,
  input  logic [CW-1:0] i_idx,
  input  logic [P*KW-1:0] i_dat,
  output logic          o_vld,
  output logic [CW-1:0] o_idx,
  output logic [P*KW-1:0] o_dat
);

  localparam int DD = DIST / P;              // partner distance in cycles
  localparam logic [CW-1:0] DD_V = CW'(DD);

  logic [P*KW-1:0] dl_dat [DD];
  logic            dl_vld [DD];
  logic [CW-1:0]   dl_idx [DD];

  logic            tail_vld;
  logic [CW-1:0]   tail_idx;
  logic [P*KW-1:0] tail_dat;
  logic            swap_now;   // upper partner present, lower partner at delay tail
  logic [P*KW-1:0] lo_dat;
  logic [P*KW-1:0] hi_dat;
  logic [P*KW-1:0] push_dat;
  logic [P*KW-1:0] emit_dat;

  assign tail_vld = dl_vld[DD-1];
  assign tail_idx = dl_idx[DD-1];
  assign tail_dat = dl_dat[DD-1];
  assign swap_now = i_vld && ((i_idx & DD_V) != '0);

  always_comb begin
    logic [KW-1:0] a;
    logic [KW-1:0] b;
    lo_dat = '0;
    hi_dat = '0;
    for (int j = 0; j < P; j++) begin
      a = tail_dat[j*KW +: KW];
      b = i_dat[j*KW +: KW];
      if (bsn_pkg::f_needs_swap(bsn_pkg::f_ascending(int'(tail_idx) * P + j, SPAN),
                                32'(a), 32'(b))) begin
        lo_dat[j*KW +: KW] = b;
        hi_dat[j*KW +: KW] = a;
      end else begin
        lo_dat[j*KW +: KW] = a;
        hi_dat[j*KW +: KW] = b;
      end
    end
  end

  assign push_dat = swap_now ? hi_dat : i_dat;
  assign emit_dat = swap_now ? lo_dat : tail_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DD; k++) begin
        dl_vld[k] <= 1'b0;
        dl_idx[k] <= '0;
        dl_dat[k] <= '0;
      end
      o_vld <= 1'b0;
      o_idx <= '0;
      o_dat <= '0;
    end else begin
      dl_vld[0] <= i_vld;
      dl_idx[0] <= i_idx;
      dl_dat[0] <= push_dat;
      for (int k = 1; k < DD; k++) begin
        dl_vld[k] <= dl_vld[k-1];
        dl_idx[k] <= dl_idx[k-1];
        dl_dat[k] <= dl_dat[k-1];
      end
      o_vld <= tail_vld;
      o_idx <= tail_idx;
      o_dat <= emit_dat;
    end
  end

  // R4: inside a contiguous block the lower partner is waiting at the tail
  a_r4_partner_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    swap_now |-> (tail_vld && tail_idx == (i_idx ^ DD_V)));

  for (genvar j = 0; j < P; j++) begin : g_chk
    // R1: the emitted lower result and the stored upper result are ordered
    a_r1_split_order: assert property (@(posedge clk) disable iff (!rst_n)
      $past(swap_now) |-> (bsn_pkg::f_ascending(int'(o_idx) * P + j, SPAN)
                           ? (o_dat[j*KW +: KW] <= dl_dat[0][j*KW +: KW])
                           : (o_dat[j*KW +: KW] >= dl_dat[0][j*KW +: KW])));
  end

endmodule

// File: rtl/bsn_sorter.sv
module bsn_sorter #(
  parameter int N  = 16,
  parameter int P  = 4,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [P*KW-1:0] in_keys,
  output logic          out_valid,
  output logic          out_start,
  output logic [P*KW-1:0] out_keys
);

  localparam int LOGN = $clog2(N);
  localparam int NB   = N / P;                          // cycles per block
  localparam int CW   = $clog2(NB);
  localparam int NSTG = bsn_pkg::f_stage_count(LOGN);

  logic [CW-1:0]   blk_cnt;
  logic [CW-1:0]   in_idx;

  logic            ch_vld [NSTG+1];
  logic [CW-1:0]   ch_idx [NSTG+1];
  logic [P*KW-1:0] ch_dat [NSTG+1];

  assign in_idx = in_start ? '0 : blk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blk_cnt <= '0;
    else if (in_valid) blk_cnt <= in_idx + 1'b1;
  end

  assign ch_vld[0] = in_valid;
  assign ch_idx[0] = in_idx;
  assign ch_dat[0] = in_keys;

  for (genvar gs = 1; gs <= LOGN; gs++) begin : g_merge
    for (genvar gk = 0; gk < gs; gk++) begin : g_col
      localparam int ST   = (gs - 1) * gs / 2 + gk;
      localparam int SPAN = 1 << gs;
      localparam int DIST = 1 << (gs - 1 - gk);
      if (DIST >= P) begin : g_mem
        bsn_delay_stage #(.P(P), .KW(KW), .CW(CW), .SPAN(SPAN), .DIST(DIST)) u_stage (
          .clk(clk), .rst_n(rst_n),
          .i_vld(ch_vld[ST]),   .i_idx(ch_idx[ST]),   .i_dat(ch_dat[ST]),
          .o_vld(ch_vld[ST+1]), .o_idx(ch_idx[ST+1]), .o_dat(ch_dat[ST+1]));
      end else begin : g_wire
        bsn_lane_stage #(.P(P), .KW(KW), .CW(CW), .SPAN(SPAN), .DIST(DIST)) u_stage (
          .clk(clk), .rst_n(rst_n),
          .i_vld(ch_vld[ST]),   .i_idx(ch_idx[ST]),   .i_dat(ch_dat[ST]),
          .o_vld(ch_vld[ST+1]), .o_idx(ch_idx[ST+1]), .o_dat(ch_dat[ST+1]));
      end
    end
  end

  assign out_valid = ch_vld[NSTG];
  assign out_start = ch_vld[NSTG] && (ch_idx[NSTG] == '0);
  assign out_keys  = ch_dat[NSTG];

  // lane-to-lane order of the word leaving the last column
  logic [P-2:0] lane_ok;
  for (genvar j = 0; j < P - 1; j++) begin : g_ord
    assign lane_ok[j] = out_keys[j*KW +: KW] <= out_keys[(j+1)*KW +: KW];
  end

  // R1: each output word is sorted across its lanes
  a_r1_lanes_sorted: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&lane_ok));

  // R1: order continues from the last lane of one cycle to the first of the next
  a_r1_cross_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start && $past(out_valid)) |->
      out_keys[KW-1:0] >= $past(out_keys[(P-1)*KW +: KW]));

  // R4: output words of a block follow each other on consecutive cycles
  a_r4_block_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_start) |->
      ($past(out_valid) && (ch_idx[NSTG] - $past(ch_idx[NSTG])) == CW'(1)));

endmodule

// File: tb/bsn_sorter_tb_top.sv
`timescale 1ns/1ps
module bsn_sorter_tb_top;

  localparam int N  = 16;
  localparam int P  = 4;
  localparam int KW = 16;
  localparam int NB = N / P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_start = 1'b0;
  logic [P*KW-1:0] in_keys = '0;
  logic          out_valid;
  logic          out_start;
  logic [P*KW-1:0] out_keys;

  bsn_sorter #(.N(N), .P(P), .KW(KW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_start(in_start), .in_keys(in_keys),
    .out_valid(out_valid), .out_start(out_start), .out_keys(out_keys));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  string idle_tag = "R6";

  int              exp_cyc [$];
  logic [P*KW-1:0] exp_dat [$];
  bit              exp_st  [$];
  string           exp_tag [$];

  int    stim [N];
  int    blk  [N];
  int    blk_cyc [NB];
  int    fill = 0;
  string blk_tag = "R1 R2";
  int    seed = 12345;

  function automatic int next_rand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return seed >>> 8;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [P*KW-1:0] act, logic [P*KW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_outputs();
    if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
      check(out_valid === 1'b1, "R3 R4", "out_valid", P*KW'(out_valid), 1);
      check(out_start === exp_st[0], "R5", "out_start", P*KW'(out_start), P*KW'(exp_st[0]));
      check(out_keys === exp_dat[0], exp_tag[0], "out_keys", out_keys, exp_dat[0]);
      void'(exp_cyc.pop_front());
      void'(exp_dat.pop_front());
      void'(exp_st.pop_front());
      void'(exp_tag.pop_front());
    end else begin
      check(out_valid === 1'b0 && out_start === 1'b0, idle_tag, "idle valid/start",
            P*KW'({out_valid, out_start}), 0);
    end
  endtask

  task automatic finish_block();
    for (int i = 1; i < N; i++) begin
      int v = blk[i];
      int k = i - 1;
      while (k >= 0 && blk[k] > v) begin
        blk[k+1] = blk[k];
        k--;
      end
      blk[k+1] = v;
    end
    for (int c = 0; c < NB; c++) begin
      logic [P*KW-1:0] w = '0;
      for (int j = 0; j < P; j++) w[j*KW +: KW] = KW'(blk[c*P+j]);
      exp_cyc.push_back(blk_cyc[c] + lat);
      exp_dat.push_back(w);
      exp_st.push_back(c == 0);
      exp_tag.push_back(blk_tag);
    end
  endtask

  task automatic step(bit vld, bit st, logic [P*KW-1:0] dat);
    @(negedge clk);
    check_outputs();
    in_valid = vld;
    in_start = st;
    in_keys  = dat;
    if (vld) begin
      for (int j = 0; j < P; j++) blk[fill*P+j] = int'(dat[j*KW +: KW]);
      blk_cyc[fill] = cyc;
      fill++;
      if (fill == NB) begin
        finish_block();
        fill = 0;
      end
    end
  endtask

  task automatic send_stim(string tag);
    blk_tag = tag;
    for (int c = 0; c < NB; c++) begin
      logic [P*KW-1:0] w = '0;
      for (int j = 0; j < P; j++) w[j*KW +: KW] = KW'(stim[c*P+j]);
      step(1'b1, c == 0, w);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    // R3: latency from the column list: one register per column plus delay depth
    for (int s = 2; s <= N; s *= 2)
      for (int d = s / 2; d >= 1; d /= 2)
        lat += 1 + ((d >= P) ? d / P : 0);

    // R6: outputs low while reset is held
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0 && out_start === 1'b0, "R6", "reset outputs",
            P*KW'({out_valid, out_start}), 0);
    end
    rst_n = 1'b1;
    idle(4);

    // back-to-back blocks, R4
    for (int i = 0; i < N; i++) stim[i] = N - i;              // descending
    send_stim("R1 R2");
    for (int i = 0; i < N; i++) stim[i] = 100 + i;            // already sorted
    send_stim("R1 R2");
    for (int i = 0; i < N; i++) stim[i] = 7;                  // all equal, R8
    send_stim("R8");
    for (int i = 0; i < N; i++) stim[i] = next_rand() % 6;    // heavy duplicates, R8
    send_stim("R8");
    for (int i = 0; i < N; i++)                               // extremes, R8
      stim[i] = (i % 3 == 0) ? 16'hffff : ((i % 3 == 1) ? 0 : 16'h8000 + i);
    send_stim("R8");

    // R7: gap between blocks
    idle_tag = "R7";
    idle(3);
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < N; i++) stim[i] = next_rand() & 16'hffff;
      send_stim("R1 R2");
    end
    idle(1);
    for (int i = 0; i < N; i++) stim[i] = (i % 2) ? 16'hffff - i : i; // interleaved
    send_stim("R1 R2");
    idle(2);
    for (int i = 0; i < N; i++) stim[i] = next_rand() & 16'hffff;
    send_stim("R1 R2");

    idle(lat + 6);
    check(exp_cyc.size() == 0, "R3", "pending words", P*KW'(exp_cyc.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule